// File: doc/BRIEF.md
# Quarter-Rate Digital IF Upconverter

This block takes a stream of filtered complex baseband samples (signed I and Q) and shifts it up to a digital intermediate frequency at one quarter of the sample rate. With a 100 MHz sample clock, that places the carrier at 25 MHz. It sums the two mixed branches into a single real IF sample stream, which can then feed a converter or a later digital stage.

Because the oscillator sits at exactly fs/4, its cosine and sine only ever take the values -1, 0 and +1. Each output sample is therefore one input picked out with the right sign, and the block needs no multiplier. Negation saturates, so the most negative code never wraps.

The current oscillator values are driven out as 2-bit signed codes next to each output sample. This lets the carrier phase be watched from outside the block.

Top module: `fs4_if_mixer`

## Requirements
- R1: While reset is asserted and after it is released, `if_valid`, `if_out`, `lo_cos` and `lo_sin` are all zero. The first valid sample after reset uses oscillator phase 0.
- R2: `if_valid` equals `in_valid` delayed by exactly one clock. Each output sample appears one clock after its input is accepted.
- R3: The oscillator phase steps 0,1,2,3,0,... Cosine takes the values +1, 0, -1, 0 over these phases, and sine takes 0, +1, 0, -1. The values are shown on `lo_cos`/`lo_sin` alongside the sample they produced, encoded as +1=2'b01, 0=2'b00, -1=2'b11.
- R4: Each output sample equals I·cos − Q·sin for its phase: I in phase 0, −Q in phase 1, −I in phase 2, +Q in phase 3.
- R5: The phase advances only on clocks where `in_valid` is high. On clocks without a valid input, `if_out`, `lo_cos` and `lo_sin` keep their previous values.
- R6: Negating the most negative input (−2^23) yields the most positive value (2^23−1) rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| i_in | input | 24 | Signed in-phase baseband sample |
| q_in | input | 24 | Signed quadrature baseband sample |
| if_out | output | 24 | Signed real IF sample |
| if_valid | output | 1 | Output sample qualifier |
| lo_cos | output | 2 | Oscillator cosine used for `if_out` (signed) |
| lo_sin | output | 2 | Oscillator sine used for `if_out` (signed) |

## Verification
The assertions assume that `i_in` and `q_in` are meaningful only while `in_valid` is high, and that `in_valid` is a clean synchronous level with no X values after reset. The stimulus drives every input on the falling edge and holds it across the rising edge. Arbitrary valid gaps, full-scale extremes in every phase and a reset in the middle of a stream all stay within those assumptions. Data driven while `in_valid` is low is random, so any leakage into the outputs would show.

// File: rtl/fs4_if_mixer.sv
module fs4_if_mixer #(
  parameter int DW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] i_in,
  input  logic signed [DW-1:0] q_in,
  output logic signed [DW-1:0] if_out,
  output logic                 if_valid,
  output logic [1:0]           lo_cos,
  output logic [1:0]           lo_sin
);

  localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [1:0] LO_POS  = 2'b01;
  localparam logic [1:0] LO_ZERO = 2'b00;
  localparam logic [1:0] LO_NEG  = 2'b11;

  logic [1:0]           ph;
  logic signed [DW-1:0] i_neg, q_neg, mix;
  logic [1:0]           cos_n, sin_n;

  assign i_neg = (i_in == SMIN) ? SMAX : -i_in;
  assign q_neg = (q_in == SMIN) ? SMAX : -q_in;

  assign cos_n = (ph == 2'd0) ? LO_POS : (ph == 2'd2) ? LO_NEG : LO_ZERO;
  assign sin_n = (ph == 2'd1) ? LO_POS : (ph == 2'd3) ? LO_NEG : LO_ZERO;

  always_comb begin
    case (ph)
      2'd0:    mix = i_in;
      2'd1:    mix = q_neg;
      2'd2:    mix = i_neg;
      default: mix = q_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= 2'd0;
      if_valid <= 1'b0;
      if_out   <= '0;
      lo_cos   <= LO_ZERO;
      lo_sin   <= LO_ZERO;
    end else begin
      if_valid <= in_valid;
      if (in_valid) begin
        ph     <= ph + 2'd1;
        if_out <= mix;
        lo_cos <= cos_n;
        lo_sin <= sin_n;
      end
    end
  end

  logic [1:0] lo_idx;
  assign lo_idx = {(lo_cos == LO_NEG) || (lo_sin == LO_NEG), lo_sin != LO_ZERO};

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> if_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !if_valid);
  a_r5_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(if_out) && $stable(lo_cos) && $stable(lo_sin)));
  a_r3_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    if_valid |-> (((lo_cos == LO_ZERO) != (lo_sin == LO_ZERO))
                  && lo_cos != 2'b10 && lo_sin != 2'b10));
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    if_valid |-> (ph == lo_idx + 2'd1));
  a_r4_pass_i: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ph == 2'd0) |=> (if_out == $past(i_in)));
  a_r4_pass_q: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ph == 2'd3) |=> (if_out == $past(q_in)));
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((ph == 2'd2 && i_in == SMIN) || (ph == 2'd1 && q_in == SMIN)))
      |=> (if_out == SMAX));

endmodule

// File: tb/fs4_if_mixer_tb.sv
module fs4_if_mixer_tb;
  localparam int DW = 24;
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] i_in = '0, q_in = '0;
  logic signed [DW-1:0] if_out;
  logic if_valid;
  logic [1:0] lo_cos, lo_sin;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  fs4_if_mixer #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .i_in(i_in), .q_in(q_in),
    .if_out(if_out), .if_valid(if_valid), .lo_cos(lo_cos), .lo_sin(lo_sin));

  // behavioural reference
  int     m_ph = 0;
  bit     e_valid = 0;
  longint e_out = 0;
  int     e_cos = 0, e_sin = 0;
  bit     e_sat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; e_valid = 0; e_out = 0; e_cos = 0; e_sin = 0; e_sat = 0;
    end else begin
      e_valid = in_valid;
      if (in_valid) begin
        longint v;
        e_cos = (m_ph == 0) ? 1 : (m_ph == 2) ? -1 : 0;
        e_sin = (m_ph == 1) ? 1 : (m_ph == 3) ? -1 : 0;
        v = e_cos * longint'(i_in) - e_sin * longint'(q_in);
        e_sat = (v > MAXV);
        e_out = e_sat ? MAXV : v;
        m_ph = (m_ph + 1) % 4;
      end
    end
  end

  function automatic logic [1:0] enc(input int x);
    return (x > 0) ? 2'b01 : (x < 0) ? 2'b11 : 2'b00;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 valid", if_valid, e_valid);
      chk("R3 cos", lo_cos, enc(e_cos));
      chk("R3 sin", lo_sin, enc(e_sin));
      chk(e_sat ? "R6 sat" : (e_valid ? "R4 mix" : "R5 hold"), longint'(if_out), e_out);
    end
  end

  task automatic drive(input bit v, input longint iv, input longint qv);
    @(negedge clk);
    in_valid = v;
    i_in = iv[DW-1:0];
    q_in = qv[DW-1:0];
  endtask

  function automatic longint rnd();
    return longint'($signed($urandom() & 32'h00ff_ffff) <<< 8) >>> 8;
  endfunction

  initial begin
    #1_600_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset
    chk("R1 rst valid", if_valid, 0);
    chk("R1 rst out", longint'(if_out), 0);
    chk("R1 rst cos", lo_cos, 0);
    chk("R1 rst sin", lo_sin, 0);
    rst_n = 1'b1;
    // continuous stream
    for (int k = 0; k < 400; k++) drive(1, rnd(), rnd());
    // gaps with garbage data (R5)
    for (int k = 0; k < 600; k++) drive(($urandom() % 3) == 0, rnd(), rnd());
    // extremes in every phase (R6)
    for (int k = 0; k < 16; k++) drive(1, MINV, MINV);
    for (int k = 0; k < 16; k++) drive(1, MAXV, MAXV);
    for (int k = 0; k < 16; k++) drive(1, (k % 2) ? MINV : MAXV, (k % 3) ? MINV : 0);
    drive(0, 0, 0);
    // mid-stream reset then first sample uses phase 0 (R1)
    drive(1, 5, 7);
    drive(1, 5, 7);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid rst out", longint'(if_out), 0);
    rst_n = 1'b1;
    drive(1, 1234, -99);
    drive(0, 0, 0);
    chk("R1 phase0 cos", lo_cos, 2'b01);
    chk("R1 phase0 out", longint'(if_out), 1234);
    for (int k = 0; k < 300; k++) drive(($urandom() % 2) == 0, rnd(), rnd());
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule